// File: doc/BRIEF.md
# Encoded-Ratio Four-Domain Clock Enable Divider

This block takes one fast source clock and produces four clock-enable pulse trains for a core domain, a high-speed bus domain, a low-speed peripheral domain and a memory domain. Each train is a one-cycle pulse that repeats every N source cycles. N comes from a 4-bit code per domain, and all four codes live in one 32-bit control word. The codes select from a fixed table of ratios that mixes powers of two with three times a power of two, so ratios such as 3, 6, 12 and 24 are available next to 2, 4, 8, 16 and 32.

Software writes the whole control word through a single write strobe and can read it back at any time. A flag in the written word chooses when the new codes take effect. When the flag is set, all four dividers switch at once. When it is clear, the new codes wait until the core divider finishes its current period, and then all four switch together. A code outside the table is refused for its own field only, and that field keeps its previous code.

Top module: `encdiv_top`

## Requirements
- R1: Codes 0 through 8 give pulse periods of 1, 2, 3, 4, 6, 8, 12, 16 and 24 source cycles, in that code order.
- R2: Code 9 is the largest legal code and gives a period of 32 source cycles.
- R3: The core code is at control bits 3:0, the high-speed bus code at 7:4, the low-speed peripheral code at 11:8 and the memory code at 15:12. Bit 22 is the change-enable flag. Each output follows only its own field.
- R4: A written field holding code 10 to 15 is refused. That field keeps its previous code, and the other fields of the same write are still accepted.
- R5: A write with bit 22 set applies its codes at once and restarts all four dividers. Each output then first pulses in the N-th cycle after the write edge, where the cycle right after that edge counts as the first.
- R6: A write with bit 22 clear leaves the running ratios in force until the next core pulse. In the cycle after that pulse all four dividers restart together on the new codes.
- R7: Every output is high for exactly one cycle per period, and consecutive pulses are exactly N cycles apart, odd N included.
- R8: After reset every code is 0 and bit 22 is clear, so reads return zero and all four outputs are high in every cycle.
- R9: A read returns the four stored codes and the last written bit 22, with all other bits zero. It shows a write from the cycle after that write's edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Stored control word |
| tick_core | output | 1 | Core domain enable pulse |
| tick_hbus | output | 1 | High-speed bus domain enable pulse |
| tick_pbus | output | 1 | Low-speed peripheral domain enable pulse |
| tick_mem | output | 1 | Memory domain enable pulse |

## Verification
The read-back and an immediate write's codes are both due in the first cycle after the write edge. The outputs are decoded from registered counters with no extra stage, so with ratio N the first pulse comes N-1 cycles after that first cycle. A deferred write takes effect in the cycle after the next core pulse, so the bench first sets a known core phase with an immediate write and only then issues the deferred write, which lets it predict that pulse. All inputs are driven and all outputs sampled on the falling clock edge, and each expected pulse train is indexed from the first cycle after the write edge.

// File: rtl/encdiv_pkg.sv
package encdiv_pkg;

  localparam int NUM_DOM     = 4;
  localparam int CODE_W      = 4;
  localparam int REG_W       = 32;
  localparam int CNT_W       = 5;
  localparam int MAX_CODE    = 9;
  localparam int CE_BIT      = 22;
  localparam int FIELD_TOTAL = NUM_DOM * CODE_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [NUM_DOM-1:0][CODE_W-1:0] code_vec_t;

  // Terminal count (ratio minus one) for a code.
  // Odd codes give powers of two, even codes above zero give three times a power of two.
  function automatic cnt_t code_to_last(code_t c);
    int n;
    if (c == '0)
      n = 1;
    else if (c >= code_t'(MAX_CODE))
      n = 1 << CNT_W;
    else if (c[0])
      n = 1 << ((int'(c) + 1) / 2);
    else
      n = 3 << (int'(c) / 2 - 1);
    return cnt_t'(n - 1);
  endfunction

endpackage

// File: rtl/encdiv_ctrl_reg.sv
module encdiv_ctrl_reg
  import encdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output code_vec_t        codes_q,
  output code_vec_t        codes_d,
  output logic             ce_q,
  output logic [REG_W-1:0] rd_data
);

  logic ce_d;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:CE_BIT+1], wr_data[CE_BIT-1:FIELD_TOTAL]};

  // Per-field merge: refused codes keep the stored value.
  always_comb begin
    for (int i = 0; i < NUM_DOM; i++) begin
      if (wr_en && (wr_data[i*CODE_W +: CODE_W] <= code_t'(MAX_CODE)))
        codes_d[i] = wr_data[i*CODE_W +: CODE_W];
      else
        codes_d[i] = codes_q[i];
    end
    ce_d = wr_en ? wr_data[CE_BIT] : ce_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codes_q <= '0;
      ce_q    <= 1'b0;
    end else if (wr_en) begin
      codes_q <= codes_d;
      ce_q    <= ce_d;
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[FIELD_TOTAL-1:0] = codes_q;
    rd_data[CE_BIT]          = ce_q;
  end

endmodule

// File: rtl/encdiv_counter.sv
module encdiv_counter
  import encdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  cnt_t last,
  output logic tick
);

  cnt_t cnt_q;
  cnt_t cnt_d;

  assign tick = (cnt_q == last);

  always_comb begin
    if (restart || tick)
      cnt_d = '0;
    else
      cnt_d = cnt_q + cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

endmodule

// File: rtl/encdiv_top.sv
module encdiv_top
  import encdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             tick_core,
  output logic             tick_hbus,
  output logic             tick_pbus,
  output logic             tick_mem
);

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  code_vec_t          codes_q;
  code_vec_t          codes_d;
  logic               ce_q;
  code_vec_t          act_q;
  code_vec_t          act_d;
  logic               pend_q;
  logic               pend_d;
  logic               imm_apply;
  logic               def_apply;
  logic               restart;
  logic [NUM_DOM-1:0] tick_v;
  logic               unused_ce;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  encdiv_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .codes_q (codes_q),
    .codes_d (codes_d),
    .ce_q    (ce_q),
    .rd_data (rd_data)
  );
  assign unused_ce = ce_q;

  // Apply control: immediate on a flagged write, otherwise at the core wrap.
  always_comb begin
    imm_apply = wr_en && wr_data[CE_BIT];
    def_apply = pend_q && tick_v[0] && !imm_apply;
    restart   = imm_apply || def_apply;
    if (imm_apply)
      act_d = codes_d;
    else if (def_apply)
      act_d = codes_q;
    else
      act_d = act_q;
    if (wr_en && !wr_data[CE_BIT])
      pend_d = 1'b1;
    else if (restart)
      pend_d = 1'b0;
    else
      pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    encdiv_counter u_cnt (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .restart (restart),
      .last    (code_to_last(act_q[g])),
      .tick    (tick_v[g])
    );
  end

  assign tick_core = tick_v[0];
  assign tick_hbus = tick_v[1];
  assign tick_pbus = tick_v[2];
  assign tick_mem  = tick_v[3];

endmodule

// File: rtl/encdiv_chk.sv
module encdiv_chk
  import encdiv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic [REG_W-1:0]   rd_data,
  input logic [NUM_DOM-1:0] tick_v,
  input logic               pend_q
);

  // R4: a refused core code leaves the stored core field as it was
  p_keep_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[CODE_W-1:0] > code_t'(MAX_CODE))) |=> (rd_data[CODE_W-1:0] == $past(rd_data[CODE_W-1:0])));

  // R9: the flag bit reads back as written
  p_flag_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[CE_BIT] == $past(wr_data[CE_BIT])));

  // R9: bits outside the fields and the flag read as zero
  p_spare_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[REG_W-1:CE_BIT+1] == '0) && (rd_data[CE_BIT-1:FIELD_TOTAL] == '0));

  // R5: after an immediate write the core pulses at once only for ratio 1
  p_imm_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CE_BIT] && (wr_data[CODE_W-1:0] <= code_t'(MAX_CODE)))
      |=> (tick_v[0] == ($past(wr_data[CODE_W-1:0]) == '0)));

  // R6: a pending change survives until a core pulse
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !tick_v[0] && !(wr_en && wr_data[CE_BIT])) |=> pend_q);

  // R6: a core pulse with no write consumes the pending change
  p_pend_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && tick_v[0] && !wr_en) |=> !pend_q);

endmodule

bind encdiv_top encdiv_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .tick_v  (tick_v),
  .pend_q  (pend_q)
);

// File: tb/sim_encdiv_top.sv
module sim_encdiv_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        tick_core, tick_hbus, tick_pbus, tick_mem;

  int tests;
  int fails;
  bit done;
  logic [3:0] exp_code [4];

  encdiv_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .tick_core (tick_core),
    .tick_hbus (tick_hbus),
    .tick_pbus (tick_pbus),
    .tick_mem  (tick_mem)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_ratio(logic [3:0] c);
    case (c)
      4'd0: return 1;
      4'd1: return 2;
      4'd2: return 3;
      4'd3: return 4;
      4'd4: return 6;
      4'd5: return 8;
      4'd6: return 12;
      4'd7: return 16;
      4'd8: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] exp_word(logic ce);
    logic [31:0] w;
    w = '0;
    for (int d = 0; d < 4; d++) w[d*4 +: 4] = exp_code[d];
    w[22] = ce;
    return w;
  endfunction

  function automatic logic [3:0] ticks();
    return {tick_mem, tick_pbus, tick_hbus, tick_core};
  endfunction

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; one write edge follows; returns at the falling edge after it.
  task automatic write_reg(logic [31:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
    // R4 rule applied in the bench shadow copy
    for (int k = 0; k < 4; k++)
      if (d[k*4 +: 4] <= 4'd9) exp_code[k] = d[k*4 +: 4];
  endtask

  // Samples len cycles from the current one; expects domain d high when i % N == N-1.
  task automatic check_pattern(string req, int len);
    int n [4];
    int bad_i [4];
    logic bad_v [4];
    for (int d = 0; d < 4; d++) begin
      n[d] = exp_ratio(exp_code[d]);
      bad_i[d] = -1;
      bad_v[d] = 1'b0;
    end
    for (int i = 0; i < len; i++) begin
      logic [3:0] t;
      t = ticks();
      for (int d = 0; d < 4; d++) begin
        if (bad_i[d] < 0 && (t[d] !== ((i % n[d]) == n[d] - 1))) begin
          bad_i[d] = i;
          bad_v[d] = t[d];
        end
      end
      if (i < len - 1) @(negedge clk);
    end
    for (int d = 0; d < 4; d++) begin
      tests++;
      if (bad_i[d] >= 0) begin
        fails++;
        $display("FAIL %s domain %0d ratio %0d cycle %0d actual=%0b expected=%0b",
                 req, d, n[d], bad_i[d], bad_v[d], !bad_v[d]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tests = 0;
    fails = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    for (int k = 0; k < 4; k++) exp_code[k] = 4'd0;
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: reset state
    check_eq("R8 reset read", rd_data, 32'h0);
    check_pattern("R8 reset ratio 1", 4);

    // R1 R3 R5 R7: distinct codes per field, immediate
    write_reg(32'h0040_8452);
    check_eq("R9 R3 readback", rd_data, exp_word(1'b1));
    check_pattern("R1 R3 R5 R7 mixed", 60);

    // R1: remaining codes
    write_reg(32'h0040_7631);
    check_pattern("R1 codes 1 3 6 7", 40);
    write_reg(32'h0040_0000);
    check_pattern("R1 code 0", 5);

    // R2: largest code
    write_reg(32'h0040_9999);
    check_eq("R2 readback", rd_data, exp_word(1'b1));
    check_pattern("R2 ratio 32", 70);

    // R4: refused fields keep old codes, others accepted
    write_reg(32'h0040_C1F2);
    check_eq("R4 refused field kept", rd_data, 32'h0040_9192);
    check_pattern("R4 refused field ratio", 70);

    // R6: deferred change waits for the core pulse
    write_reg(32'h0040_1113);
    write_reg(32'h0000_0000);
    check_eq("R9 R6 deferred readback", rd_data, 32'h0000_0000);
    begin
      logic [3:0] exp_seq [6];
      exp_seq[0] = 4'b1110; exp_seq[1] = 4'b0000; exp_seq[2] = 4'b1111;
      exp_seq[3] = 4'b1111; exp_seq[4] = 4'b1111; exp_seq[5] = 4'b1111;
      for (int i = 0; i < 6; i++) begin
        check_eq("R6 deferred switch", {28'h0, ticks()}, {28'h0, exp_seq[i]});
        if (i < 5) @(negedge clk);
      end
    end

    // R4 R5 R7 R9: random immediate writes
    for (int it = 0; it < 24; it++) begin
      @(negedge clk);
      d = $urandom();
      d[22] = 1'b1;
      write_reg(d);
      check_eq("R9 R4 random readback", rd_data, exp_word(1'b1));
      check_pattern("R5 R7 random", 70);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule